// File: doc/BRIEF.md
# Tile Background Pixel Pipeline

This block turns the screen coordinate being scanned out into a background colour index. Every clock it accepts an X/Y pair with a valid flag. It finds the 8x8 tile that covers that pixel and fetches the tile's code from a tile RAM. It also fetches a colour attribute for the tile's screen region from a colour PROM, then fetches the two bitplane bytes of the tile's graphics from a pair of tile ROMs. From these it builds a 6-bit palette index. The tile grid is read with X inverted, which matches a display mounted on its side.

All four stores sit outside the block and answer on their synchronous read ports one clock after they are addressed. The block drives the addresses and holds the low coordinate bits and the attribute in pipeline registers, so that each pixel's data meets its own coordinates. A result appears three clocks after its coordinates.

Top module: `tile_bg_pipe`

## Requirements
- R1: `tram_addr` equals ({Y[7:3], ~X[7:3]} + 0x40) modulo 1024 for the coordinates on the inputs in the same cycle; the carry out of bit 9 is dropped.
- R2: `cprom_addr` equals `tram_addr` with bits 6 and 5 removed, i.e. {tram_addr[9:7], tram_addr[4:0]}, in the same cycle.
- R3: For a valid pixel, `out_colour[5:2]` equals the low 4 bits of the colour PROM word read at that pixel's `cprom_addr`.
- R4: One clock after a pixel's coordinates, `gfx_addr` equals {tile code read for that pixel, ~X[2:0]}; both tile ROMs are read at this address.
- R5: For a valid pixel, `out_colour[1]` is bit Y[2:0] of the plane-1 ROM byte and `out_colour[0]` is bit Y[2:0] of the plane-0 ROM byte.
- R6: `out_valid` is high in exactly those cycles that come three clocks after a cycle with `in_valid` high, when no reset intervenes.
- R7: While `out_valid` is low, `out_colour` is zero.
- R8: A low `rst_n` sampled at a rising clock edge clears every pipeline valid bit, so `out_valid` is low after that edge and no pixel that was in flight is delivered.
- R9: Coordinates at the wrap corner give wrapped addresses: X=0, Y=255 gives `tram_addr` 0x03F and X=255, Y=255 gives 0x020.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Coordinates on pix_x/pix_y are a pixel to render |
| pix_x | input | 8 | Screen X coordinate |
| pix_y | input | 8 | Screen Y coordinate |
| tram_addr | output | 10 | Tile RAM read address |
| tram_data | input | 8 | Tile code, one clock after tram_addr |
| cprom_addr | output | 8 | Colour PROM read address |
| cprom_data | input | 4 | Colour attribute, one clock after cprom_addr |
| gfx_addr | output | 11 | Read address shared by both tile ROMs |
| gfx0_data | input | 8 | Plane-0 byte, one clock after gfx_addr |
| gfx1_data | input | 8 | Plane-1 byte, one clock after gfx_addr |
| out_valid | output | 1 | out_colour holds a rendered pixel |
| out_colour | output | 6 | Palette index {attribute, plane 1 bit, plane 0 bit} |

## Verification
On every cycle the assertions check that the valid flag emerges exactly three clocks after it entered, that the colour stays zero when nothing is valid, and that a reset edge empties the pipeline. They also check that the colour address is the tile address with its two middle bits squeezed out, that the tile address's low field follows the inverted X tile column, and that the ROM column bits follow the inverted low X bits of the previous cycle. Only the bench's scenarios can show that the right attribute and the right bitplane bits reach the right pixel. For that it models the four stores with computed contents and compares every output against an independently computed colour. The bench also covers the base-offset wrap at the grid corners and a reset that lands with pixels still in flight.

// File: rtl/tbp_pkg.sv
// Shared defaults for the tile background pipeline.
// Assumes a square tile whose side is a power of two and two bitplanes.
package tbp_pkg;
    localparam int unsigned TBP_COORD_W   = 8;   // screen coordinate width
    localparam int unsigned TBP_TILE_LG   = 3;   // log2 of the tile side
    localparam int unsigned TBP_CODE_W    = 8;   // tile code width
    localparam int unsigned TBP_ATTR_W    = 4;   // colour attribute bits used
    localparam int unsigned TBP_TRAM_BASE = 64;  // offset added to the tile index
    localparam int unsigned TBP_PLANES    = 2;   // bitplanes per pixel
endpackage

// File: rtl/tbp_addr_gen.sv
// Tile address generator.
// Turns a screen coordinate into the tile RAM and colour PROM addresses and
// splits off the in-tile offsets. Purely combinational; assumes the stores
// register the address themselves. The X tile column is inverted and the
// base is added modulo the RAM size.
module tbp_addr_gen
    import tbp_pkg::*;
#(
    parameter int unsigned COORD_W   = TBP_COORD_W,
    parameter int unsigned TILE_LG   = TBP_TILE_LG,
    parameter int unsigned TRAM_BASE = TBP_TRAM_BASE,
    localparam int unsigned TILE_FLD = COORD_W - TILE_LG,
    localparam int unsigned TRAM_AW  = 2 * TILE_FLD,
    localparam int unsigned CPROM_AW = TRAM_AW - 2
) (
    input  logic [COORD_W-1:0]  x,
    input  logic [COORD_W-1:0]  y,
    output logic [TRAM_AW-1:0]  tram_addr,
    output logic [CPROM_AW-1:0] cprom_addr,
    output logic [TILE_LG-1:0]  col_inv,
    output logic [TILE_LG-1:0]  row
);
    localparam logic [TRAM_AW-1:0] BASE_V = TRAM_AW'(TRAM_BASE);

    logic [TRAM_AW-1:0] tile_idx;

    // Build the tile index with the X column mirrored, then add the base with wrap.
    always_comb begin
        tile_idx  = {y[COORD_W-1:TILE_LG], ~x[COORD_W-1:TILE_LG]};
        tram_addr = tile_idx + BASE_V;
    end

    // Colour address: drop the two lowest bits of the tile row field.
    always_comb begin
        cprom_addr = {tram_addr[TRAM_AW-1:TILE_FLD+2], tram_addr[TILE_FLD-1:0]};
    end

    // In-tile offsets: the mirrored column picks the ROM byte, the row picks the bit.
    always_comb begin
        col_inv = ~x[TILE_LG-1:0];
        row     = y[TILE_LG-1:0];
    end
endmodule

// File: rtl/tbp_stage.sv
// One pipeline stage: a valid bit with synchronous active-low reset and a
// data word that loads every clock and is never reset (its value only
// matters while the valid bit is set).
module tbp_stage #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_v,
    input  logic [W-1:0] in_d,
    output logic         out_v,
    output logic [W-1:0] out_d
);
    // Valid bit: cleared by reset, otherwise follows the upstream valid.
    always_ff @(posedge clk) begin
        if (!rst_n) out_v <= 1'b0;
        else        out_v <= in_v;
    end

    // Data word: follows the upstream data every clock.
    always_ff @(posedge clk) begin
        out_d <= in_d;
    end
endmodule

// File: rtl/tbp_plane_pick.sv
// Bitplane bit selector.
// From each plane's byte picks the bit addressed by the pixel row.
// Assumes each plane byte holds one bit per row of the tile.
module tbp_plane_pick
    import tbp_pkg::*;
#(
    parameter int unsigned TILE_LG = TBP_TILE_LG,
    parameter int unsigned PLANES  = TBP_PLANES,
    localparam int unsigned PLANE_W = 1 << TILE_LG
) (
    input  logic [PLANES-1:0][PLANE_W-1:0] planes,
    input  logic [TILE_LG-1:0]             row,
    output logic [PLANES-1:0]              bits
);
    for (genvar p = 0; p < PLANES; p++) begin : g_plane
        // Row-indexed bit of plane p.
        assign bits[p] = planes[p][row];
    end
endmodule

// File: rtl/tile_bg_pipe.sv
// Tile background pixel pipeline (top).
// Cycle 0: coordinates in, tile RAM and colour PROM addressed.
// Cycle 1: tile code back, tile ROMs addressed with {code, mirrored column}.
// Cycle 2: plane bytes back, row bit picked and joined with the attribute.
// Cycle 3: colour index out, forced to zero when not valid.
// Assumes every external store has exactly one clock of read latency.
module tile_bg_pipe
    import tbp_pkg::*;
#(
    parameter int unsigned COORD_W   = TBP_COORD_W,
    parameter int unsigned TILE_LG   = TBP_TILE_LG,
    parameter int unsigned CODE_W    = TBP_CODE_W,
    parameter int unsigned ATTR_W    = TBP_ATTR_W,
    parameter int unsigned TRAM_BASE = TBP_TRAM_BASE,
    localparam int unsigned TILE_FLD = COORD_W - TILE_LG,
    localparam int unsigned TRAM_AW  = 2 * TILE_FLD,
    localparam int unsigned CPROM_AW = TRAM_AW - 2,
    localparam int unsigned GFX_AW   = CODE_W + TILE_LG,
    localparam int unsigned PLANE_W  = 1 << TILE_LG,
    localparam int unsigned PLANES   = TBP_PLANES,
    localparam int unsigned COLOUR_W = ATTR_W + PLANES
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [COORD_W-1:0]  pix_x,
    input  logic [COORD_W-1:0]  pix_y,
    output logic [TRAM_AW-1:0]  tram_addr,
    input  logic [CODE_W-1:0]   tram_data,
    output logic [CPROM_AW-1:0] cprom_addr,
    input  logic [ATTR_W-1:0]   cprom_data,
    output logic [GFX_AW-1:0]   gfx_addr,
    input  logic [PLANE_W-1:0]  gfx0_data,
    input  logic [PLANE_W-1:0]  gfx1_data,
    output logic                out_valid,
    output logic [COLOUR_W-1:0] out_colour
);
    logic [TILE_LG-1:0] s0_col, s0_row;
    logic               a_v;
    logic [TILE_LG-1:0] a_col, a_row;
    logic               b_v;
    logic [TILE_LG-1:0] b_row;
    logic [ATTR_W-1:0]  b_attr;
    logic [PLANES-1:0]  pix_bits;
    logic               c_v;
    logic [COLOUR_W-1:0] c_colour;
    logic [PLANES-1:0][PLANE_W-1:0] plane_bytes;

    tbp_addr_gen #(
        .COORD_W  (COORD_W),
        .TILE_LG  (TILE_LG),
        .TRAM_BASE(TRAM_BASE)
    ) u_addr (
        .x         (pix_x),
        .y         (pix_y),
        .tram_addr (tram_addr),
        .cprom_addr(cprom_addr),
        .col_inv   (s0_col),
        .row       (s0_row)
    );

    // Stage A: offsets wait for the tile code and attribute.
    tbp_stage #(.W(2 * TILE_LG)) u_stage_a (
        .clk  (clk),
        .rst_n(rst_n),
        .in_v (in_valid),
        .in_d ({s0_col, s0_row}),
        .out_v(a_v),
        .out_d({a_col, a_row})
    );

    // Tile ROM address from the fetched code and the mirrored column.
    always_comb begin
        gfx_addr = {tram_data, a_col};
    end

    // Stage B: attribute and row wait for the plane bytes.
    tbp_stage #(.W(ATTR_W + TILE_LG)) u_stage_b (
        .clk  (clk),
        .rst_n(rst_n),
        .in_v (a_v),
        .in_d ({cprom_data, a_row}),
        .out_v(b_v),
        .out_d({b_attr, b_row})
    );

    // Group the plane bytes with plane 0 at index 0.
    always_comb begin
        plane_bytes = {gfx1_data, gfx0_data};
    end

    tbp_plane_pick #(
        .TILE_LG(TILE_LG),
        .PLANES (PLANES)
    ) u_pick (
        .planes(plane_bytes),
        .row   (b_row),
        .bits  (pix_bits)
    );

    // Stage C: registered colour index.
    tbp_stage #(.W(COLOUR_W)) u_stage_c (
        .clk  (clk),
        .rst_n(rst_n),
        .in_v (b_v),
        .in_d ({b_attr, pix_bits}),
        .out_v(c_v),
        .out_d(c_colour)
    );

    // Output gate: a non-valid slot shows colour zero.
    always_comb begin
        out_valid  = c_v;
        out_colour = c_v ? c_colour : '0;
    end
endmodule

// File: rtl/tile_bg_pipe_chk.sv
// Property checker for tile_bg_pipe, attached by bind below.
// Counts clocks since reset so that no look-back reaches before it.
module tile_bg_pipe_chk #(
    parameter int unsigned COORD_W  = 8,
    parameter int unsigned TILE_LG  = 3,
    parameter int unsigned GFX_AW   = 11,
    parameter int unsigned COLOUR_W = 6,
    localparam int unsigned TILE_FLD = COORD_W - TILE_LG,
    localparam int unsigned TRAM_AW  = 2 * TILE_FLD,
    localparam int unsigned CPROM_AW = TRAM_AW - 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic [COORD_W-1:0]  pix_x,
    input logic [TRAM_AW-1:0]  tram_addr,
    input logic [CPROM_AW-1:0] cprom_addr,
    input logic [GFX_AW-1:0]   gfx_addr,
    input logic                out_valid,
    input logic [COLOUR_W-1:0] out_colour
);
    logic [1:0] since_rst;

    // Saturating count of clocks since reset was released.
    always_ff @(posedge clk) begin
        if (!rst_n)                since_rst <= 2'd0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    p_tile_col_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tram_addr[TILE_FLD-1:0] == ~pix_x[COORD_W-1:TILE_LG]);

    p_colour_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cprom_addr == {tram_addr[TRAM_AW-1:TILE_FLD+2], tram_addr[TILE_FLD-1:0]});

    p_rom_col_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst != 2'd0) |-> gfx_addr[TILE_LG-1:0] == ~$past(pix_x[TILE_LG-1:0]));

    p_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3) |-> out_valid == $past(in_valid, 3));

    p_idle_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> out_colour == '0);

    p_reset_flush_r8: assert property (@(posedge clk)
        !rst_n |=> !out_valid);
endmodule

bind tile_bg_pipe tile_bg_pipe_chk #(
    .COORD_W (COORD_W),
    .TILE_LG (TILE_LG),
    .GFX_AW  (GFX_AW),
    .COLOUR_W(COLOUR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .pix_x     (pix_x),
    .tram_addr (tram_addr),
    .cprom_addr(cprom_addr),
    .gfx_addr  (gfx_addr),
    .out_valid (out_valid),
    .out_colour(out_colour)
);

// File: tb/tile_bg_pipe_tb_top.sv
module tile_bg_pipe_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  pix_x = '0;
    logic [7:0]  pix_y = '0;
    logic [9:0]  tram_addr;
    logic [7:0]  tram_data;
    logic [7:0]  cprom_addr;
    logic [3:0]  cprom_data;
    logic [10:0] gfx_addr;
    logic [7:0]  gfx0_data;
    logic [7:0]  gfx1_data;
    logic        out_valid;
    logic [5:0]  out_colour;

    int checks = 0;
    int errors = 0;

    // Pipeline history of what was driven: index 0 newest.
    logic       hv [3];
    logic [7:0] hx [3];
    logic [7:0] hy [3];

    always #10 clk = ~clk;

    tile_bg_pipe dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .pix_x(pix_x), .pix_y(pix_y),
        .tram_addr(tram_addr), .tram_data(tram_data),
        .cprom_addr(cprom_addr), .cprom_data(cprom_data),
        .gfx_addr(gfx_addr), .gfx0_data(gfx0_data), .gfx1_data(gfx1_data),
        .out_valid(out_valid), .out_colour(out_colour)
    );

    // Store contents, computed.
    function automatic logic [7:0] f_code(input logic [9:0] a);
        logic [15:0] t = 16'(a) * 16'd73 + 16'(a >> 4);
        return t[7:0] ^ 8'hC3;
    endfunction
    function automatic logic [3:0] f_attr(input logic [7:0] a);
        logic [7:0] t = a * 8'd5 + 8'd3;
        return t[3:0] ^ a[7:4];
    endfunction
    function automatic logic [7:0] f_p0(input logic [10:0] a);
        logic [15:0] t = 16'(a) * 16'd29 + 16'd7;
        return t[7:0] ^ a[10:3];
    endfunction
    function automatic logic [7:0] f_p1(input logic [10:0] a);
        logic [15:0] t = 16'(a) * 16'd151 + 16'd90;
        return t[9:2] ^ a[7:0];
    endfunction

    // One-clock synchronous store models.
    always @(posedge clk) begin
        tram_data  <= f_code(tram_addr);
        cprom_data <= f_attr(cprom_addr);
        gfx0_data  <= f_p0(gfx_addr);
        gfx1_data  <= f_p1(gfx_addr);
    end

    function automatic logic [9:0] e_tram(input logic [7:0] x, input logic [7:0] y);
        return {y[7:3], ~x[7:3]} + 10'h040;
    endfunction
    function automatic logic [7:0] e_cprom(input logic [9:0] a);
        return {a[9:7], a[4:0]};
    endfunction
    function automatic logic [10:0] e_gfx(input logic [7:0] x, input logic [7:0] y);
        return {f_code(e_tram(x, y)), ~x[2:0]};
    endfunction
    function automatic logic [5:0] e_colour(input logic [7:0] x, input logic [7:0] y);
        logic [10:0] g = e_gfx(x, y);
        logic [7:0]  b0 = f_p0(g);
        logic [7:0]  b1 = f_p1(g);
        return {f_attr(e_cprom(e_tram(x, y))), b1[y[2:0]], b0[y[2:0]]};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    // One clock: check outputs of the pixel from three clocks ago, then drive.
    task automatic step(input logic r, input logic v, input logic [7:0] x, input logic [7:0] y);
        @(negedge clk);
        check("R6 out_valid", 32'(out_valid), 32'(hv[2]));
        if (hv[2]) begin
            check("R3 attribute bits", 32'(out_colour[5:2]), 32'(e_colour(hx[2], hy[2]) >> 2));
            check("R5 plane bits", 32'(out_colour[1:0]), 32'(e_colour(hx[2], hy[2]) & 6'h3));
        end else begin
            check("R7 idle colour zero", 32'(out_colour), 32'd0);
        end
        check("R4 rom address", 32'(gfx_addr), 32'(e_gfx(hx[0], hy[0])));
        rst_n = r;
        if (!r) begin
            for (int i = 0; i < 3; i++) hv[i] = 1'b0;
        end
        hv[2] = hv[1]; hx[2] = hx[1]; hy[2] = hy[1];
        hv[1] = hv[0]; hx[1] = hx[0]; hy[1] = hy[0];
        hv[0] = v & r; hx[0] = x; hy[0] = y;
        in_valid = v; pix_x = x; pix_y = y;
        #1;
        check("R1 tile address", 32'(tram_addr), 32'(e_tram(x, y)));
        check("R2 colour address", 32'(cprom_addr), 32'(e_cprom(e_tram(x, y))));
    endtask

    initial begin
        for (int i = 0; i < 3; i++) begin hv[i] = 1'b0; hx[i] = '0; hy[i] = '0; end
        void'($urandom(32'd4242));
        // Reset: outputs idle (R8, R7).
        for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 8'd0, 8'd0);
        @(negedge clk);
        check("R8 reset out_valid low", 32'(out_valid), 32'd0);
        check("R7 reset colour zero", 32'(out_colour), 32'd0);
        // Directed corners (R9 wrap).
        step(1'b1, 1'b1, 8'd0, 8'd255);
        check("R9 wrap corner 0,255", 32'(tram_addr), 32'h03F);
        step(1'b1, 1'b1, 8'd255, 8'd255);
        check("R9 wrap corner 255,255", 32'(tram_addr), 32'h020);
        step(1'b1, 1'b1, 8'd0, 8'd0);
        step(1'b1, 1'b1, 8'd255, 8'd0);
        step(1'b1, 1'b0, 8'd77, 8'd12);
        step(1'b1, 1'b1, 8'd7, 8'd7);
        // A full scan line sweep within one tile row, every row offset.
        for (int i = 0; i < 256; i++) step(1'b1, 1'b1, 8'(i), 8'(i / 32 + 64));
        // Random pixels with random valid gaps.
        for (int i = 0; i < 3000; i++)
            step(1'b1, ($urandom % 4) != 0, 8'($urandom), 8'($urandom));
        // Reset with pixels in flight (R8).
        step(1'b1, 1'b1, 8'd10, 8'd20);
        step(1'b1, 1'b1, 8'd11, 8'd21);
        step(1'b0, 1'b1, 8'd12, 8'd22);
        step(1'b1, 1'b1, 8'd13, 8'd23);
        check("R8 flushed after reset", 32'(out_valid), 32'd0);
        for (int i = 0; i < 500; i++)
            step(1'b1, ($urandom % 3) != 0, 8'($urandom), 8'($urandom));
        for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 8'd0, 8'd0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog.
    initial begin
        #(20 * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule